// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the bit-level core of a single-lane SPI master. It takes words from a transmit FIFO (first-word-fall-through: `tx_data` is valid whenever `tx_valid` is high, and `tx_pop` consumes it) and serialises them on `mosi`. At the same time it assembles the bits arriving on `miso` into words and hands each finished word to a receive FIFO with a one-cycle `rx_push` strobe. The block clock is the external SPI reference. `sck` runs at that clock divided by the even parameter `CLK_RATIO` (2 to 2048). Clock polarity, clock phase and bit order are set by plain inputs. Software keeps them steady while `busy` is high.

A transfer burst needs two conditions: `en` must be high and `master_inhibit` must be low. Because of this, software can fill the transmit FIFO and drive the chip-select vector first, then release the whole burst with a single control change. Once a word has started, it always completes. Words keep flowing back to back with no idle gap for as long as the FIFO holds data and the gate stays open. `ss_n` is a registered copy of the slave-select input vector and is active low. Bit `WORD_W-1` is the most significant bit in both shift orders.

The control state machine has three states:
- `ST_IDLE`: `sck` rests at `cpol`.
- `ST_DRIVE`: the first half of a bit period. The bit is on `mosi`.
- `ST_SAMPLE`: the second half of a bit period.

Its transitions are:
- *start*: `ST_IDLE`→`ST_DRIVE`, when the gate is open and a word is waiting. The word is popped.
- *capture*: `ST_DRIVE`→`ST_SAMPLE`, at the end of a half-period. `miso` is sampled.
- *next bit*: `ST_SAMPLE`→`ST_DRIVE`, when bits remain in the word. The shift register advances.
- *chain*: `ST_SAMPLE`→`ST_DRIVE`, on the last bit when another word may start. That word is popped.
- *finish*: `ST_SAMPLE`→`ST_IDLE`, on the last bit when no further word may start.

Top module: `spi_xfer_engine`

## Requirements
- R1: Every `sck` level inside a transfer lasts exactly `CLK_RATIO/2` clock cycles, and while no transfer is in progress `sck` equals `cpol`.
- R2: During the first half of each bit `sck` is `cpol ^ cpha` and during the second half `cpol ^ ~cpha`. With `cpha`=0 the bit is on `mosi` before the first edge and is sampled on the leading edge. With `cpha`=1 the bit changes on the leading edge and is sampled on the trailing edge.
- R3: With `lsb_first`=0 a word leaves bit `WORD_W-1` first and bit 0 last. With `lsb_first`=1 it leaves bit 0 first. Bit `WORD_W-1` is the MSB in both cases.
- R4: Received bits are placed in the same bit order as transmitted bits. `rx_push` is high for one cycle: the first cycle after the clock edge that samples the last bit of a word, with the finished word on `rx_data`.
- R5: While `master_inhibit`=1 or `en`=0, no word is popped, `busy` stays 0 and `sck` stays at `cpol`, even with `tx_valid`=1.
- R6: A burst of N queued words keeps `busy` high for exactly N·`WORD_W`·`CLK_RATIO` cycles without a gap between words.
- R7: `ss_n` equals the value `ss_sel` had one clock earlier, whatever the transfer state, and it resets to all ones. A 0 in bit k selects slave k.
- R8: `busy` rises in the cycle after a word is popped from idle. It falls only at the end of the second half of the last bit of a word.
- R9: Setting `master_inhibit` during a word lets that word finish and then stops. No further word is popped.
- R10: `tx_pop` is a single-cycle pulse per word and is raised only while `tx_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External SPI reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Engine enable |
| master_inhibit | input | 1 | Holds back new words while high |
| lsb_first | input | 1 | 1: bit 0 shifted first; 0: bit WORD_W-1 first |
| cpol | input | 1 | Idle level of sck |
| cpha | input | 1 | Clock phase select |
| ss_sel | input | NUM_SS | Slave-select register value, active low |
| tx_valid | input | 1 | Transmit FIFO holds a word |
| tx_data | input | WORD_W | Head word of transmit FIFO |
| tx_pop | output | 1 | Consume head word of transmit FIFO |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | NUM_SS | Registered slave selects, active low |
| busy | output | 1 | A word is being shifted |
| rx_push | output | 1 | Received word strobe |
| rx_data | output | WORD_W | Received word |

## Verification
The hardest case to reach from the ports is the mid-word stop (R9). `master_inhibit` has to rise after a word has started, but before the last half-period in which the engine decides whether to chain the next word. The stimulus waits for the `rx_push` of the first word of a three-word burst and sets the inhibit at that moment. That is inside the final half-period. The remaining queue length then shows that exactly one word was taken. A loopback of `mosi` into `miso` lets a single bus-side decoder check the transmit and receive bit orders in all four polarity and phase combinations.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DRIVE  = 2'd1,
        ST_SAMPLE = 2'd2
    } eng_state_e;

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R1
    half_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(tick)) |-> (cnt == '0));

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic         sample,
    input  logic         last,
    input  logic         lsb_first,
    input  logic [W-1:0] din,
    input  logic         miso,
    output logic         mosi,
    output logic [W-1:0] rx_word,
    output logic         rx_push
);
    logic [W-1:0] tx_sh;
    logic [W-1:0] rx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (load) begin
            tx_sh <= din;
        end else if (shift) begin
            tx_sh <= lsb_first ? (tx_sh >> 1) : (tx_sh << 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh   <= '0;
            rx_push <= 1'b0;
        end else begin
            rx_push <= sample && last;
            if (sample) begin
                rx_sh <= lsb_first ? {miso, rx_sh[W-1:1]} : {rx_sh[W-2:0], miso};
            end
        end
    end

    assign mosi    = lsb_first ? tx_sh[0] : tx_sh[W-1];
    assign rx_word = rx_sh;

    // R4
    rx_push_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> !rx_push);

endmodule

// File: rtl/spi_fsm.sv
module spi_fsm
    import spi_eng_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic inhibit,
    input  logic tx_valid,
    input  logic tick,
    input  logic cpol,
    input  logic cpha,
    output logic load,
    output logic shift,
    output logic sample,
    output logic last,
    output logic run,
    output logic sck
);
    localparam int BW = $clog2(W);

    eng_state_e state, state_nx;
    logic [BW-1:0] bit_idx;
    logic go;

    assign go   = en && !inhibit && tx_valid;
    assign last = (bit_idx == BW'(W - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (go) state_nx = ST_DRIVE;
            ST_DRIVE:  if (tick) state_nx = ST_SAMPLE;
            ST_SAMPLE: begin
                if (tick) begin
                    if (!last || go) state_nx = ST_DRIVE;
                    else             state_nx = ST_IDLE;
                end
            end
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load   = 1'b0;
        shift  = 1'b0;
        sample = 1'b0;
        run    = 1'b0;
        sck    = cpol;
        unique case (state)
            ST_IDLE: begin
                load = go;
            end
            ST_DRIVE: begin
                run    = 1'b1;
                sck    = cpol ^ cpha;
                sample = tick;
            end
            ST_SAMPLE: begin
                run   = 1'b1;
                sck   = cpol ^ ~cpha;
                shift = tick && !last;
                load  = tick && last && go;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx <= '0;
        end else if (load) begin
            bit_idx <= '0;
        end else if (shift) begin
            bit_idx <= bit_idx + 1'b1;
        end
    end

    // R10
    pop_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> tx_valid);

    // R5
    gate_closed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && (inhibit || !en)) |=> (state == ST_IDLE));

    // R8
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> $past(state == ST_SAMPLE && tick && last));

    // R8
    pop_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> run);

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine #(
    parameter int WORD_W    = 8,
    parameter int NUM_SS    = 4,
    parameter int CLK_RATIO = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              master_inhibit,
    input  logic              lsb_first,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [NUM_SS-1:0] ss_sel,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_pop,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic [NUM_SS-1:0] ss_n,
    output logic              busy,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_data
);
    localparam int HALF = CLK_RATIO / 2;

    logic tick;
    logic run;
    logic shift;
    logic sample;
    logic last;

    spi_half_timer #(.HALF(HALF)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    spi_fsm #(.W(WORD_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .inhibit  (master_inhibit),
        .tx_valid (tx_valid),
        .tick     (tick),
        .cpol     (cpol),
        .cpha     (cpha),
        .load     (tx_pop),
        .shift    (shift),
        .sample   (sample),
        .last     (last),
        .run      (run),
        .sck      (sck)
    );

    spi_shifter #(.W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_pop),
        .shift     (shift),
        .sample    (sample),
        .last      (last),
        .lsb_first (lsb_first),
        .din       (tx_data),
        .miso      (miso),
        .mosi      (mosi),
        .rx_word   (rx_data),
        .rx_push   (rx_push)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ss_n <= '1;
        end else begin
            ss_n <= ss_sel;
        end
    end

    assign busy = run;

    // R7
    ss_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (ss_n == $past(ss_sel)));

    // R1
    sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> ($stable(sck) || !$stable(cpol) || !$stable(cpha)));

endmodule

// File: tb/sim_spi_xfer_engine.sv
module sim_spi_xfer_engine;
    localparam int W     = 8;
    localparam int NSS   = 4;
    localparam int RATIO = 4;
    localparam int H     = RATIO / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic inhibit = 1'b1;
    logic lsb = 1'b0;
    logic cpol = 1'b0;
    logic cpha = 1'b0;
    logic [NSS-1:0] ss_sel = '1;
    logic tx_valid = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic tx_pop, sck, mosi, busy, rx_push;
    logic [NSS-1:0] ss_n;
    logic [W-1:0] rx_data;
    logic miso;

    assign miso = mosi;

    spi_xfer_engine #(.WORD_W(W), .NUM_SS(NSS), .CLK_RATIO(RATIO)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .master_inhibit(inhibit),
        .lsb_first(lsb), .cpol(cpol), .cpha(cpha), .ss_sel(ss_sel),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
        .miso(miso), .sck(sck), .mosi(mosi), .ss_n(ss_n),
        .busy(busy), .rx_push(rx_push), .rx_data(rx_data)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [W-1:0] txq[$];
    logic [W-1:0] exp_tx[$];
    logic [W-1:0] exp_rx[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // transmit FIFO model (first-word-fall-through)
    always @(posedge clk) begin
        if (tx_pop && txq.size() > 0) void'(txq.pop_front());
        tx_valid <= (txq.size() != 0);
        tx_data  <= (txq.size() != 0) ? txq[0] : '0;
    end

    // scoreboard monitor
    logic sck_prev = 1'b0;
    int bit_k = 0;
    int edge_cnt = 0;
    bit have_edge = 1'b0;
    bit final_now;
    logic [W-1:0] word_acc = '0;
    logic [W-1:0] e;

    always @(negedge clk) begin
        final_now = 1'b0;
        if (!rst_n) begin
            bit_k = 0; edge_cnt = 0; have_edge = 1'b0;
        end else begin
            if (busy) begin
                edge_cnt++;
                if (sck != sck_prev) begin
                    if (have_edge) chk(edge_cnt == H, "R1 half-period", edge_cnt, H);
                    have_edge = 1'b1;
                    edge_cnt  = 0;
                    if (sck == (cpol ^ ~cpha)) begin
                        if (lsb) word_acc[bit_k] = mosi;
                        else     word_acc[W-1-bit_k] = mosi;
                        bit_k++;
                        if (bit_k == W) begin
                            bit_k = 0;
                            final_now = 1'b1;
                            if (exp_tx.size() == 0) chk(1'b0, "R2/R3 unexpected word", word_acc, 0);
                            else begin
                                e = exp_tx.pop_front();
                                chk(word_acc == e, "R2/R3 mosi word", word_acc, e);
                            end
                        end
                    end
                end
            end else begin
                have_edge = 1'b0;
                edge_cnt  = 0;
            end
            if (rx_push || final_now) begin
                chk(rx_push && final_now, "R4 push timing", {rx_push, final_now}, 2'b11);
                if (rx_push) begin
                    if (exp_rx.size() == 0) chk(1'b0, "R4 unexpected rx", rx_data, 0);
                    else begin
                        e = exp_rx.pop_front();
                        chk(rx_data == e, "R4 rx word", rx_data, e);
                    end
                end
            end
        end
        sck_prev = sck;
    end

    task automatic queue_word(input logic [W-1:0] w);
        txq.push_back(w);
        exp_tx.push_back(w);
        exp_rx.push_back(w);
    endtask

    task automatic burst(input int n);
        int cnt;
        @(negedge clk); en = 1'b1; inhibit = 1'b0;
        @(negedge clk);
        chk(busy === 1'b1, "R8 busy after pop", busy, 1);
        chk(sck === (cpol ^ cpha), "R2 first half level", sck, cpol ^ cpha);
        cnt = 1;
        while (busy) begin
            @(negedge clk);
            if (busy) cnt++;
        end
        chk(cnt == n * W * RATIO, "R6 busy length", cnt, n * W * RATIO);
        inhibit = 1'b1;
        chk(txq.size() == 0, "R10 words popped", txq.size(), 0);
        chk(exp_tx.size() == 0 && exp_rx.size() == 0, "R3/R4 all seen", exp_tx.size(), 0);
    endtask

    task automatic set_mode(input logic p, input logic h, input logic l);
        @(negedge clk); cpol = p; cpha = h; lsb = l;
        repeat (2) @(negedge clk);
        chk(sck === p && busy === 1'b0, "R1 idle level", sck, p);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(sck === 1'b0 && busy === 1'b0, "R8 reset idle", {sck, busy}, 0);
        chk(ss_n === '1, "R7 reset ss_n", ss_n, 4'hF);
        chk(tx_pop === 1'b0 && rx_push === 1'b0, "R10 reset strobes", {tx_pop, rx_push}, 0);
        rst_n = 1'b1;

        // R7: slave select follows register
        @(negedge clk); ss_sel = 4'b1110;
        @(negedge clk);
        chk(ss_n === 4'b1110, "R7 select slave 0", ss_n, 4'b1110);

        // R5: inhibit blocks queued words
        en = 1'b1; inhibit = 1'b1;
        queue_word(8'hA5); queue_word(8'h3C);
        repeat (20) @(negedge clk);
        chk(busy === 1'b0 && sck === cpol, "R5 inhibit idle", {busy, sck}, 0);
        chk(txq.size() == 2, "R5 inhibit no pop", txq.size(), 2);
        // R5: disabled engine blocks too
        en = 1'b0; inhibit = 1'b0;
        repeat (20) @(negedge clk);
        chk(busy === 1'b0 && sck === cpol, "R5 disabled idle", {busy, sck}, 0);
        chk(txq.size() == 2, "R5 disabled no pop", txq.size(), 2);
        burst(2);

        set_mode(1'b0, 1'b1, 1'b0);
        queue_word(8'h81); queue_word(8'h7E); queue_word(8'hC3);
        repeat (2) @(negedge clk);
        burst(3);

        set_mode(1'b1, 1'b0, 1'b1);
        queue_word(8'h01); queue_word(8'h80); queue_word(8'h5A);
        repeat (2) @(negedge clk);
        burst(3);

        set_mode(1'b1, 1'b1, 1'b1);
        queue_word(8'hF0); queue_word(8'h0E);
        repeat (2) @(negedge clk);
        burst(2);

        // R9: inhibit raised inside a word
        set_mode(1'b0, 1'b0, 1'b0);
        queue_word(8'h96); queue_word(8'h69); queue_word(8'hFF);
        repeat (2) @(negedge clk);
        inhibit = 1'b0;
        while (!rx_push) @(negedge clk);
        inhibit = 1'b1;
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(txq.size() == 2, "R9 one word taken", txq.size(), 2);
        chk(busy === 1'b0 && sck === cpol, "R9 stopped idle", {busy, sck}, 0);
        burst(2);

        @(negedge clk); ss_sel = 4'b1011;
        @(negedge clk);
        chk(ss_n === 4'b1011, "R7 select slave 2", ss_n, 4'b1011);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R8 actual=hung expected=idle");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule